// File: doc/BRIEF.md
# Grouped Daisy-Chain Interrupt Controller

This block decides which of many interrupting devices the processor core services next. Devices are arranged in groups. Each group has one shared request and one acknowledge path that runs through its members in a fixed order. Every device has a pending flag, which is set by a one-cycle event pulse, and an enable bit. A device asks for service only while both are set. The groups rank by a fixed level: group g carries level g+1, so the highest-numbered group is the most urgent.

The controller keeps a current processor level. It raises `irq_out` toward the core only when all of these hold: the global enable is set, the best requesting group ranks strictly above the current level, and the nesting store still has room.

When the core pulses `intr_ack` while `irq_out` is high, the controller accepts the interrupt:
- The acknowledge travels down the winning group's chain to the nearest requesting device, which is shown as a one-hot pulse on `dev_ack`.
- That device's pending flag clears.
- The old level is saved and the current level rises to the group's level.
- One cycle later the device's identifying code appears on `vec` with `vec_valid`.

A return pulse (`rti`) restores the last saved level. Software can also write the level directly. The vector path carries no back-pressure: the core has already committed by pulsing `intr_ack`, so `vec_valid` is a single-cycle strobe with no ready input.

Top module: `irq_ctrl`

## Requirements
- R1: An event pulse on `dev_event[i]` sets device i's pending flag. A pending device whose `dev_en[i]` is 0 does not contribute to `irq_out` and is never acknowledged, and it becomes eligible as soon as its enable is set.
- R2: Device d of group g is bit g*4+d of `dev_event`, `dev_en` and `dev_ack`, where d=0 is the device nearest the controller. On acceptance, `dev_ack` is one-hot in the same cycle as `intr_ack`, and it selects the lowest-indexed enabled pending device of the winning group.
- R3: Among groups with an enabled pending device, the highest group index wins. Group g has level g+1.
- R4: `irq_out` is 1 exactly when all of these hold: `gie`=1, some enabled device is pending, the winning group's level is greater than `run_lvl`, and fewer than 4 levels are saved.
- R5: On acceptance, `run_lvl` takes the winning group's level from the next cycle on, and the previous `run_lvl` is saved.
- R6: In the cycle after acceptance, `vec_valid` is 1 for exactly one cycle and `vec` = {2'b10, group[1:0], device[1:0]}.
- R7: Acceptance clears the acknowledged device's pending flag, unless a new event for that device arrives in the same cycle, in which case the flag stays set.
- R8: `intr_ack` while `irq_out` is 0 has no effect: `dev_ack` stays 0, `vec_valid` stays 0, and neither the level nor any pending flag changes.
- R9: `rti` restores the most recently saved level. With nothing saved, `rti` leaves `run_lvl` unchanged.
- R10: `lvl_wr` loads `lvl_wdata` into `run_lvl`. If acceptance, `rti` and `lvl_wr` coincide, acceptance wins over `rti`, and `rti` wins over `lvl_wr`.
- R11: Once 4 levels are saved, `irq_out` stays 0 even when a request outranks `run_lvl`.
- R12: After reset, all pending flags are clear, `run_lvl` is 0, no level is saved, and `irq_out`, `dev_ack` and `vec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_event | input | 16 | Per-device event pulses that set pending |
| dev_en | input | 16 | Per-device interrupt enables |
| gie | input | 1 | Global acceptance enable |
| lvl_wr | input | 1 | Load `lvl_wdata` into the current level |
| lvl_wdata | input | 3 | Level value to load |
| rti | input | 1 | Return pulse: restore the last saved level |
| intr_ack | input | 1 | Acknowledge pulse from the core |
| irq_out | output | 1 | Interrupt request toward the core |
| dev_ack | output | 16 | One-hot acknowledge routed to the chosen device |
| vec_valid | output | 1 | Vector strobe, one cycle after acceptance |
| vec | output | 6 | Identifying code of the accepted device |
| run_lvl | output | 3 | Current processor priority level |

## Verification
Directed patterns separate each ranking rule:
- Two devices pending in one group show that the position in the chain picks the device.
- Pending devices in two groups show that the group index picks the group.
- A disabled pending device, a cleared global enable and a raised current level each show a different reason for `irq_out` to stay low.

Nesting is driven to the full depth of four, then software lowers the level, which shows that a full store blocks requests that would otherwise be accepted. Return pulses with an empty store, a colliding event and acknowledge, and coinciding control pulses exercise the ordering rules. A long random phase with mixed enables and pulses is checked cycle by cycle against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // operation applied to the level store in a cycle
  typedef enum logic [1:0] {
    LOP_NONE = 2'd0,
    LOP_TAKE = 2'd1,
    LOP_RET  = 2'd2,
    LOP_SET  = 2'd3
  } lvl_op_e;
endpackage

// File: rtl/irqc_chain.sv
// One group: pending flags plus the acknowledge chain through its devices.
module irqc_chain #(
  parameter int DEVS = 4,
  localparam int DW = (DEVS > 1) ? $clog2(DEVS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DEVS-1:0] ev,
  input  logic [DEVS-1:0] en,
  input  logic            ack_in,
  output logic            grp_req,
  output logic [DEVS-1:0] ack_out,
  output logic [DW-1:0]   first_idx
);
  logic [DEVS-1:0] pend_q;
  logic [DEVS-1:0] live;
  logic [DEVS:0]   pass;

  assign live    = pend_q & en;
  assign grp_req = |live;
  assign pass[0] = ack_in;

  // acknowledge stops at the first live device, moves on otherwise
  for (genvar i = 0; i < DEVS; i++) begin : g_link
    assign ack_out[i] = pass[i] & live[i];
    assign pass[i+1]  = pass[i] & ~live[i];
  end

  always_comb begin
    first_idx = '0;
    for (int i = DEVS - 1; i >= 0; i--) begin
      if (live[i]) first_idx = DW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_out) | ev;
  end
endmodule

// File: rtl/irqc_pick.sv
// Fixed ranking between groups: highest index wins.
module irqc_pick #(
  parameter int GROUPS = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic [GROUPS-1:0] req,
  output logic              any,
  output logic [GW-1:0]     win
);
  assign any = |req;

  always_comb begin
    win = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (req[g]) win = GW'(g);
    end
  end
endmodule

// File: rtl/irqc_lvl.sv
// Current level register with a small store of saved levels.
module irqc_lvl
  import irqc_pkg::*;
#(
  parameter int LW    = 3,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lvl_op_e       op,
  input  logic [LW-1:0] new_lvl,
  output logic [LW-1:0] cur,
  output logic          full
);
  logic [LW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx;
  logic [IW-1:0] push_idx;

  assign full     = (cnt_q == CW'(DEPTH));
  assign push_idx = cnt_q[IW-1:0];
  assign top_idx  = IW'(cnt_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      unique case (op)
        LOP_TAKE: begin
          if (!full) begin
            mem_q[push_idx] <= cur;
            cnt_q           <= cnt_q + CW'(1);
          end
          cur <= new_lvl;
        end
        LOP_RET: begin
          if (cnt_q != '0) begin
            cur   <= mem_q[top_idx];
            cnt_q <= cnt_q - CW'(1);
          end
        end
        LOP_SET:  cur <= new_lvl;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int DEVS   = 4,
  parameter int DEPTH  = 4,
  parameter int VEC_W  = 6,
  parameter int PREFIX = 2,
  localparam int N  = GROUPS * DEVS,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int DW = (DEVS > 1) ? $clog2(DEVS) : 1,
  localparam int LW = $clog2(GROUPS + 1),
  localparam int PW = VEC_W - GW - DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     dev_event,
  input  logic [N-1:0]     dev_en,
  input  logic             gie,
  input  logic             lvl_wr,
  input  logic [LW-1:0]    lvl_wdata,
  input  logic             rti,
  input  logic             intr_ack,
  output logic             irq_out,
  output logic [N-1:0]     dev_ack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec,
  output logic [LW-1:0]    run_lvl
);
  logic [GROUPS-1:0] grp_req;
  logic [GROUPS-1:0] grp_ack;
  logic [DW-1:0]     first_idx [GROUPS];
  logic              any_req;
  logic [GW-1:0]     win;
  logic [LW-1:0]     win_lvl;
  logic              stk_full;
  logic              take;
  lvl_op_e           op;
  logic [LW-1:0]     new_lvl;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    irqc_chain #(.DEVS(DEVS)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (dev_event[g*DEVS +: DEVS]),
      .en        (dev_en[g*DEVS +: DEVS]),
      .ack_in    (grp_ack[g]),
      .grp_req   (grp_req[g]),
      .ack_out   (dev_ack[g*DEVS +: DEVS]),
      .first_idx (first_idx[g])
    );
    assign grp_ack[g] = take && (win == GW'(g));
  end

  irqc_pick #(.GROUPS(GROUPS)) u_pick (
    .req (grp_req),
    .any (any_req),
    .win (win)
  );

  assign win_lvl = LW'(win) + LW'(1);
  assign irq_out = gie && any_req && (win_lvl > run_lvl) && !stk_full;
  assign take    = intr_ack && irq_out;

  always_comb begin
    op      = LOP_NONE;
    new_lvl = lvl_wdata;
    if (take) begin
      op      = LOP_TAKE;
      new_lvl = win_lvl;
    end else if (rti) begin
      op = LOP_RET;
    end else if (lvl_wr) begin
      op = LOP_SET;
    end
  end

  irqc_lvl #(.LW(LW), .DEPTH(DEPTH)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .new_lvl (new_lvl),
    .cur     (run_lvl),
    .full    (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= take;
      if (take) vec <= {PW'(PREFIX), win, first_idx[win]};
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N  = 16,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie,
  input logic          intr_ack,
  input logic          irq_out,
  input logic [N-1:0]  dev_ack,
  input logic          vec_valid,
  input logic [LW-1:0] run_lvl,
  input logic          stk_full
);
  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));
  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_ack && !irq_out) |-> (dev_ack == '0));
  // R6
  vec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |=> vec_valid);
  // R6
  vec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|dev_ack)) |=> !vec_valid);
  // R5
  lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |=> (run_lvl > $past(run_lvl)));
  // R4
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> gie);
  // R11
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_out);
endmodule

bind irq_ctrl irqc_chk #(.N(N), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gie       (gie),
  .intr_ack  (intr_ack),
  .irq_out   (irq_out),
  .dev_ack   (dev_ack),
  .vec_valid (vec_valid),
  .run_lvl   (run_lvl),
  .stk_full  (stk_full)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  localparam int NG = 4;
  localparam int ND = 4;
  localparam int N  = NG * ND;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_event = '0;
  logic [N-1:0] dev_en = '0;
  logic         gie = 1'b0;
  logic         lvl_wr = 1'b0;
  logic [2:0]   lvl_wdata = '0;
  logic         rti = 1'b0;
  logic         intr_ack = 1'b0;
  logic         irq_out;
  logic [N-1:0] dev_ack;
  logic         vec_valid;
  logic [5:0]   vec;
  logic [2:0]   run_lvl;

  irq_ctrl u0 (.*);

  always #4 clk = ~clk;   // 125 MHz

  int total = 0;
  int bad = 0;
  string tag = "R12";

  // behavioural model state
  bit m_pend [N];
  int m_run = 0;
  int m_stk [$];
  bit m_vv = 0;
  int m_vec = 0;

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: compare at negedge+2, advance model, move to next negedge
  task automatic cyc();
    int best;
    int dsel;
    int lvl;
    bit irq;
    bit take;
    logic [N-1:0] ackx;
    #2;
    best = -1;
    dsel = 0;
    for (int g = NG - 1; g >= 0 && best < 0; g--)
      for (int d = 0; d < ND; d++)
        if (m_pend[g*ND+d] && dev_en[g*ND+d]) begin best = g; break; end
    if (best >= 0)
      for (int d = ND - 1; d >= 0; d--)
        if (m_pend[best*ND+d] && dev_en[best*ND+d]) dsel = d;
    lvl  = best + 1;
    irq  = gie && best >= 0 && lvl > m_run && m_stk.size() < 4;
    take = intr_ack && irq;
    ackx = '0;
    if (take) ackx[best*ND+dsel] = 1'b1;
    chk("irq_out", int'(irq_out), int'(irq));
    chk("dev_ack", int'(dev_ack), int'(ackx));
    chk("vec_valid", int'(vec_valid), int'(m_vv));
    if (m_vv) chk("vec", int'(vec), m_vec);
    chk("run_lvl", int'(run_lvl), m_run);
    // next state
    if (take) begin
      m_stk.push_back(m_run);
      m_run = lvl;
      m_pend[best*ND+dsel] = 0;
    end else if (rti) begin
      if (m_stk.size() > 0) m_run = m_stk.pop_back();
    end else if (lvl_wr) begin
      m_run = int'(lvl_wdata);
    end
    for (int i = 0; i < N; i++) if (dev_event[i]) m_pend[i] = 1;
    m_vv = take;
    if (take) m_vec = (2 << 4) | (best << 2) | dsel;
    @(negedge clk);
    dev_event = '0;
    intr_ack  = 1'b0;
    rti       = 1'b0;
    lvl_wr    = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic fire(int idx);
    dev_event[idx] = 1'b1;
    cyc();
  endtask

  task automatic ack();
    intr_ack = 1'b1;
    cyc();
  endtask

  task automatic ret();
    rti = 1'b1;
    cyc();
  endtask

  task automatic setlvl(int v);
    lvl_wr = 1'b1;
    lvl_wdata = 3'(v);
    cyc();
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_pend[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    tag = "R12";
    chk("reset irq_out", int'(irq_out), 0);
    chk("reset vec_valid", int'(vec_valid), 0);
    chk("reset run_lvl", int'(run_lvl), 0);
    idle(2);

    // R1: disabled device pends silently, then enabling exposes it
    tag = "R1";
    gie = 1'b1;
    fire(5);
    idle(2);
    chk("disabled irq_out", int'(irq_out), 0);
    dev_en = '1;
    idle(1);
    chk("enabled irq_out", int'(irq_out), 1);
    ack();
    ret();

    // R2: nearest device in a chain served first
    tag = "R2";
    dev_event[4+3] = 1'b1;
    fire(4+1);
    ack();
    ret();
    ack();
    ret();

    // R3: higher group wins
    tag = "R3";
    dev_event[0] = 1'b1;
    fire(8+2);
    ack();
    ret();
    ack();
    ret();

    // R4: global enable and level gating
    tag = "R4";
    gie = 1'b0;
    fire(3);
    idle(2);
    gie = 1'b1;
    setlvl(1);
    idle(2);
    setlvl(0);
    ack();
    ret();

    // R8: ack while nothing requested
    tag = "R8";
    ack();
    idle(1);

    // R9: return with empty store
    tag = "R9";
    setlvl(2);
    ret();
    idle(1);
    setlvl(0);

    // R10: rti beats lvl_wr; accept beats both
    tag = "R10";
    fire(12);
    lvl_wr = 1'b1; lvl_wdata = 3'd3; rti = 1'b1; intr_ack = 1'b1;
    cyc();
    lvl_wr = 1'b1; lvl_wdata = 3'd1; rti = 1'b1;
    cyc();
    idle(1);

    // R7: event on acknowledged device in the same cycle keeps it pending
    tag = "R7";
    fire(1);
    dev_event[1] = 1'b1; intr_ack = 1'b1;
    cyc();
    ret();
    idle(1);
    ack();
    ret();

    // R11: nest to full depth, then lower level in software
    tag = "R11";
    fire(0);  ack();
    fire(4);  ack();
    fire(8);  ack();
    fire(12); ack();
    setlvl(0);
    fire(2);
    idle(3);
    chk("full blocks irq_out", int'(irq_out), 0);
    ret(); ret(); ret(); ret();
    idle(1);
    ack();
    ret();

    // R5 R6: random mix against the model
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      dev_event = N'($urandom) & N'($urandom) & N'($urandom);
      dev_en    = N'($urandom) | N'($urandom);
      gie       = ($urandom % 8) != 0;
      intr_ack  = ($urandom % 3) == 0;
      rti       = ($urandom % 5) == 0;
      lvl_wr    = ($urandom % 17) == 0;
      lvl_wdata = 3'($urandom % 5);
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule